// File: doc/BRIEF.md
# Software Trap Call Sequencer

This block carries out the software trap instruction as a vectored call spread over several cycles. When the decoder starts it with the trap opcode, it moves the stack pointer down by two and pushes the return address to the new top of stack through a word write port. Once that write is acknowledged, it fetches the handler address from a fixed vector location through a word read port and loads it into the program counter. It then reports completion, with the new stack pointer and program counter valid in the same cycle.

The sequencer has no interrupt-enable input, so the trap runs whatever the global enable flag holds. It never touches the status-word flags. It drives an interrupt-inhibit line that tells the interrupt controller not to take a hardware interrupt at the instruction boundary that directly follows the trap.

Top module: `trap_call_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `wr_req`, `rd_req`, `done` and `irq_inhibit` are all 0, and `sp_out` and `pc_out` are 0.
- R2: A trap starts only when `start` is high while idle and `opcode` equals 8'hF7. A `start` that comes with any other opcode is ignored: `busy` and `wr_req` stay 0.
- R3: In the cycle after the start, `wr_req` rises with `wr_addr` = `sp_in` - 2 (taken modulo 2^16, so 16'h0000 gives 16'hFFFE) and `wr_data` = `ret_pc`. Both values stay stable and `wr_req` stays high until the cycle in which `wr_ack` is high.
- R4: `rd_req` rises in the cycle after `wr_ack` is accepted, with `rd_addr` = 16'h2010. `rd_req` and `wr_req` are never high together.
- R5: In the cycle after `rd_ack` is accepted, `done` is high for exactly one cycle, with `pc_out` = the `rd_data` sampled with `rd_ack` and `sp_out` = `sp_in` - 2. Both outputs hold those values afterwards.
- R6: A `start` pulse while `busy` is high has no effect on the trap in progress: the write address, the data and the final outputs are those of the first start.
- R7: `irq_inhibit` is high in the `done` cycle and stays high until `instr_done` is seen in a later cycle. It is low from the cycle after that strobe. An `instr_done` in the `done` cycle itself does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue strobe from decode |
| opcode | input | 8 | Opcode byte that comes with `start` |
| sp_in | input | 16 | Current stack pointer |
| ret_pc | input | 16 | Address of the instruction after the trap |
| wr_req | output | 1 | Stack write request |
| wr_addr | output | 16 | Stack write address |
| wr_data | output | 16 | Stack write word (return address) |
| wr_ack | input | 1 | Stack write accepted |
| rd_req | output | 1 | Vector read request |
| rd_addr | output | 16 | Vector read address |
| rd_ack | input | 1 | Vector read data valid |
| rd_data | input | 16 | Vector word |
| instr_done | input | 1 | Instruction-complete strobe from the core |
| busy | output | 1 | Trap in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Updated stack pointer |
| pc_out | output | 16 | Handler address |
| irq_inhibit | output | 1 | Interrupt-inhibit for the next boundary |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a step of two and the vector at 16'h2010. With these values a stack pointer of zero is in reach, so it shows whether the decrement wraps to 16'hFFFE. Directed scenarios set the acknowledge latencies to zero and to several cycles, which exercises both back-to-back handshakes and request-hold behaviour. They also place the instruction-complete strobe both in the completion cycle and after it, to cover the inhibit window at each edge.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam logic [7:0] TRAP_OPCODE = 8'hF7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PUSH  = 2'd1,
        ST_FETCH = 2'd2,
        ST_DONE  = 2'd3
    } trap_state_e;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          SP_STEP  = 2,
    parameter logic [15:0] VEC_ADDR = 16'h2010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] ret_pc,
    input  logic          wr_ack,
    input  logic          rd_ack,
    input  logic [AW-1:0] rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] wr_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] sp_out,
    output logic [AW-1:0] pc_out
);
    localparam logic [AW-1:0] STEP = AW'(SP_STEP);
    localparam logic [AW-1:0] VEC  = AW'(VEC_ADDR);

    typedef struct packed {
        trap_state_e   state;
        logic [AW-1:0] sp;
        logic [AW-1:0] pc;
        logic [AW-1:0] ret;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start && (opcode == TRAP_OPCODE)) begin
                    r_d.sp    = sp_in - STEP;
                    r_d.ret   = ret_pc;
                    r_d.state = ST_PUSH;
                end
            end
            ST_PUSH: begin
                if (wr_ack) begin
                    r_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (rd_ack) begin
                    r_d.pc    = rd_data;
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, sp: '0, pc: '0, ret: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_req  = (r_q.state == ST_PUSH);
    assign wr_addr = r_q.sp;
    assign wr_data = r_q.ret;
    assign rd_req  = (r_q.state == ST_FETCH);
    assign rd_addr = VEC;
    assign busy    = (r_q.state != ST_IDLE);
    assign done    = (r_q.state == ST_DONE);
    assign sp_out  = r_q.sp;
    assign pc_out  = r_q.pc;
endmodule

// File: rtl/trap_inhibit.sv
module trap_inhibit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic inhibit_o
);
    typedef struct packed {
        logic hold;
    } inh_t;

    inh_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set_i) begin
            s_d.hold = 1'b1;
        end else if (s_q.hold && clr_i) begin
            s_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{hold: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign inhibit_o = set_i | s_q.hold;
endmodule

// File: rtl/trap_call_seq.sv
module trap_call_seq #(
    parameter int          AW       = 16,
    parameter int          SP_STEP  = 2,
    parameter logic [15:0] VEC_ADDR = 16'h2010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] ret_pc,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] wr_data,
    input  logic          wr_ack,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [AW-1:0] rd_data,
    input  logic          instr_done,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] sp_out,
    output logic [AW-1:0] pc_out,
    output logic          irq_inhibit
);
    logic done_w;

    trap_ctrl #(
        .AW       (AW),
        .SP_STEP  (SP_STEP),
        .VEC_ADDR (VEC_ADDR)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .opcode  (opcode),
        .sp_in   (sp_in),
        .ret_pc  (ret_pc),
        .wr_ack  (wr_ack),
        .rd_ack  (rd_ack),
        .rd_data (rd_data),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .busy    (busy),
        .done    (done_w),
        .sp_out  (sp_out),
        .pc_out  (pc_out)
    );

    trap_inhibit u_inh (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (done_w),
        .clr_i     (instr_done),
        .inhibit_o (irq_inhibit)
    );

    assign done = done_w;
endmodule

// File: rtl/trap_call_seq_chk.sv
module trap_call_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [7:0]    opcode,
    input logic          wr_req,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] wr_data,
    input logic          wr_ack,
    input logic          rd_req,
    input logic          rd_ack,
    input logic          instr_done,
    input logic          busy,
    input logic          done,
    input logic          irq_inhibit
);
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && rd_req)); // R4
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data))); // R3
    AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> $past(wr_req && wr_ack)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rd_req && rd_ack)); // R5
    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && opcode != trap_pkg::TRAP_OPCODE) |=> !busy); // R2
    AST_INH_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> irq_inhibit); // R7
    AST_INH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_inhibit && instr_done && !done) |=> !irq_inhibit); // R7
endmodule

bind trap_call_seq trap_call_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .opcode      (opcode),
    .wr_req      (wr_req),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_ack      (wr_ack),
    .rd_req      (rd_req),
    .rd_ack      (rd_ack),
    .instr_done  (instr_done),
    .busy        (busy),
    .done        (done),
    .irq_inhibit (irq_inhibit)
);

// File: tb/test_trap_call_seq.sv
module test_trap_call_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] sp_in = '0;
    logic [15:0] ret_pc = '0;
    logic        wr_ack = 1'b0;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_data = '0;
    logic        instr_done = 1'b0;
    logic        wr_req, rd_req, busy, done, irq_inhibit;
    logic [15:0] wr_addr, wr_data, rd_addr, sp_out, pc_out;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_call_seq i_trap_call_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .sp_in(sp_in), .ret_pc(ret_pc), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ack(wr_ack), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .instr_done(instr_done),
        .busy(busy), .done(done), .sp_out(sp_out), .pc_out(pc_out),
        .irq_inhibit(irq_inhibit)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Runs one trap. bump_busy pulses start with other values mid-trap (R6);
    // idone_at_done strobes instr_done in the done cycle (R7).
    task automatic do_trap(input logic [15:0] sp, input logic [15:0] npc, input logic [15:0] vec,
                           input int wlat, input int rlat, input bit bump_busy, input bit idone_at_done);
        logic [15:0] exp_sp;
        exp_sp = sp - 16'd2;
        start = 1'b1; opcode = 8'hF7; sp_in = sp; ret_pc = npc;
        tick();
        start = 1'b0;
        check(wr_req == 1'b1, "R3 wr_req", 32'(wr_req), 1);
        check(wr_addr == exp_sp, "R3 wr_addr", 32'(wr_addr), 32'(exp_sp));
        check(wr_data == npc, "R3 wr_data", 32'(wr_data), 32'(npc));
        for (int i = 0; i < wlat; i++) begin
            if (bump_busy && i == 0) begin
                start = 1'b1; sp_in = sp + 16'h0100; ret_pc = npc + 16'h0040;
            end
            tick();
            start = 1'b0;
            check(wr_req && wr_addr == exp_sp && wr_data == npc, "R6 R3 write held",
                  {wr_addr, wr_data}, {exp_sp, npc});
            check(!rd_req, "R4 no read during write", 32'(rd_req), 0);
        end
        wr_ack = 1'b1;
        tick();
        wr_ack = 1'b0;
        check(!wr_req && rd_req, "R4 read follows write", {30'd0, wr_req, rd_req}, 1);
        check(rd_addr == 16'h2010, "R4 rd_addr", 32'(rd_addr), 32'h2010);
        for (int i = 0; i < rlat; i++) begin
            tick();
            check(rd_req && !done, "R4 read held", {30'd0, rd_req, done}, 2);
        end
        rd_ack = 1'b1; rd_data = vec;
        tick();
        rd_ack = 1'b0; rd_data = 16'hDEAD;
        check(done == 1'b1, "R5 done", 32'(done), 1);
        check(pc_out == vec, "R5 pc_out", 32'(pc_out), 32'(vec));
        check(sp_out == exp_sp, "R5 sp_out", 32'(sp_out), 32'(exp_sp));
        check(irq_inhibit == 1'b1, "R7 inhibit at done", 32'(irq_inhibit), 1);
        instr_done = idone_at_done;
        tick();
        instr_done = 1'b0;
        check(!done && !busy, "R5 done single cycle", {30'd0, done, busy}, 0);
        check(pc_out == vec && sp_out == exp_sp, "R5 outputs hold", {sp_out, pc_out}, {exp_sp, vec});
        check(irq_inhibit == 1'b1, "R7 inhibit kept after done", 32'(irq_inhibit), 1);
    endtask

    task automatic clear_inhibit(input int gap);
        for (int i = 0; i < gap; i++) begin
            tick();
            check(irq_inhibit == 1'b1, "R7 inhibit waits for strobe", 32'(irq_inhibit), 1);
        end
        instr_done = 1'b1;
        tick();
        instr_done = 1'b0;
        check(irq_inhibit == 1'b0, "R7 inhibit cleared", 32'(irq_inhibit), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check(!busy && !wr_req && !rd_req && !done && !irq_inhibit, "R1 idle outputs",
              {27'd0, busy, wr_req, rd_req, done, irq_inhibit}, 0);
        check(sp_out == 0 && pc_out == 0, "R1 sp/pc zero", {sp_out, pc_out}, 0);
    endtask

    task automatic t_bad_opcode();
        start = 1'b1; opcode = 8'hF6; sp_in = 16'h4000; ret_pc = 16'h1234;
        tick();
        start = 1'b0;
        check(!busy && !wr_req, "R2 other opcode ignored", {30'd0, busy, wr_req}, 0);
        start = 1'b1; opcode = 8'h77;
        tick();
        start = 1'b0;
        check(!busy && !wr_req, "R2 opcode 77 ignored", {30'd0, busy, wr_req}, 0);
        tick();
        check(!busy, "R2 still idle", 32'(busy), 0);
    endtask

    task automatic t_basic();
        do_trap(16'h0200, 16'h8452, 16'hA000, 0, 0, 1'b0, 1'b0);
        clear_inhibit(0);
    endtask

    task automatic t_latency();
        do_trap(16'h01F0, 16'h2222, 16'h3456, 3, 2, 1'b0, 1'b1);
        clear_inhibit(2);
    endtask

    task automatic t_wrap();
        do_trap(16'h0000, 16'hFFFF, 16'h0010, 1, 1, 1'b0, 1'b0);
        clear_inhibit(1);
    endtask

    task automatic t_busy_restart();
        do_trap(16'h8000, 16'h5A5A, 16'hC3C0, 2, 0, 1'b1, 1'b0);
        clear_inhibit(0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_bad_opcode();
        t_basic();
        t_latency();
        t_wrap();
        t_busy_restart();
        repeat (2) tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule